// File: doc/BRIEF.md
# Four-Bank DRAM Command Timing Guard

This block sits beside the command path of a controller for a four-bank low-power DDR memory. Every cycle the controller presents one candidate command (row open, column read, column write, bank close, close-all, or refresh) together with a bank number. The guard answers at once, combinationally, whether that command may go onto the memory bus in this cycle without breaking any minimum-delay rule. When the controller raises the issue strobe and the guard answers yes, the guard books the command into its per-bank and shared cycle counters.

The guard also keeps track of column commands that close their own row once the burst is done. Such a bank sits in a closing state: no new work reaches it, and it closes by itself once both its row-active minimum and its column recovery have run out. The other banks stay fully usable in the meantime. Every limit is a parameter given in clock cycles. The guard drives no data pins and does not reorder or queue requests.

A second output separates commands that are simply too early from commands that make no sense in the current bank state. A per-bank open mask shows which rows are open or still closing.

Top module: `lpddr_bank_guard`

## Requirements
- R1: After reset every bit of `bank_open` is 0, a row-open command to any bank reports `cmd_ok`=1, and a refresh reports `cmd_ok`=1.
- R2: Command codes on `cmd_op` are 0 no-op, 1 row open, 2 read, 3 write, 4 close, 5 refresh. A row open is accepted no earlier than T_RRD cycles after any accepted row open. From the cycle after it is accepted until that bank closes, the bank's bit in `bank_open` is 1.
- R3: A row open to a bank is accepted no earlier than T_RC cycles after the previous row open to the same bank.
- R4: A read or write to an open bank is accepted no earlier than T_RCD cycles after that bank's row open.
- R5: An explicit close of an open bank waits until T_RAS cycles have passed since its row open, BURST_LEN/2 cycles since its last read, and BURST_LEN/2+1+T_WR cycles since its last write.
- R6: After a bank closes, whether by command or by itself, a row open to it is accepted no earlier than T_RP cycles later.
- R7: A read to any bank is accepted no earlier than BURST_LEN/2+1+T_WTR cycles after the last accepted write to any bank.
- R8: On a close command, `cmd_a10`=1 closes every open bank and needs all of them to be ready. `cmd_a10`=0 closes only `cmd_bank`. Closing an idle bank is accepted and changes nothing.
- R9: A read or write issued with `cmd_a10`=1 puts the bank into a closing state. It closes by itself in the first cycle in which the R5 limits are met, so `bank_open` drops one cycle later. While it is closing, a read or write to it is illegal and a close that involves it is held off. Other banks still accept commands.
- R10: `cmd_illegal` is 1 for a read or write to a bank that is not open (idle or closing), a row open to an open bank, a refresh while any bank is open, and codes 6 and 7. Whenever `cmd_illegal` is 1, `cmd_ok` is 0.
- R11: A refresh is accepted only when all banks are idle and their T_RP has run out. After it, every command except a no-op reports `cmd_ok`=0 for T_RFC cycles.
- R12: A command strobed with `cmd_issue`=1 while `cmd_ok`=0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_op | input | 3 | Candidate command code |
| cmd_bank | input | 2 | Target bank of the candidate command |
| cmd_a10 | input | 1 | Auto-close flag on read/write, all-banks flag on close |
| cmd_issue | input | 1 | The candidate is placed on the bus this cycle |
| cmd_ok | output | 1 | The candidate meets every timing and state rule now |
| cmd_illegal | output | 1 | The candidate is not valid in the present bank state |
| bank_open | output | 4 | One bit per bank: row open or closing |

## Verification
The bench probes each limit one cycle before and exactly at its boundary. An off-by-one counter load therefore shows up as a command that is allowed too soon or refused at the boundary. It runs a write with auto-close in which column recovery outlasts the row-active minimum, and a read with auto-close in which the reverse holds. A design that closed on only one of the two limits would drop the open bit in the wrong cycle, or would let the reopen come too soon. It probes another bank during the closing window and a close-all against a closing bank, to catch a guard that stalls every bank or lets a close through. It strobes a too-early row open and then reads the open mask, to show that a refused command leaves no trace. It also probes refresh against open, recovering and idle banks.

// File: rtl/lbg_pkg.sv
`timescale 1ns/1ps
// Shared types for the bank timing guard.
// Assumes the command code values below are fixed by the controller.
package lbg_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_REF  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_CLOSING = 2'd2
    } bank_st_e;

endpackage

// File: rtl/lbg_bank.sv
`timescale 1ns/1ps
// One bank's state and its cycle counters.
// It holds the row state (idle, open, closing under auto-close) and
// counts down each per-bank limit. A counter loaded with N-1 reads
// zero exactly N cycles after the load.
// Assumes every go input is already qualified by the guard's legality.
module lbg_bank
    import lbg_pkg::*;
#(
    parameter int T_RCD  = 3,
    parameter int T_RAS  = 7,
    parameter int T_RC   = 11,
    parameter int T_RP   = 3,
    parameter int RD2PRE = 2,
    parameter int WR2PRE = 6,
    parameter int CW     = 6
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     act_go,
    input  logic     rd_go,
    input  logic     wr_go,
    input  logic     ap,
    input  logic     pre_go,
    output bank_st_e state,
    output logic     rcd_ok,
    output logic     ras_ok,
    output logic     rc_ok,
    output logic     rp_ok,
    output logic     rec_ok
);

    localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] L_RAS = CW'(T_RAS - 1);
    localparam logic [CW-1:0] L_RC  = CW'(T_RC - 1);
    localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_RDP = CW'(RD2PRE - 1);
    localparam logic [CW-1:0] L_WRP = CW'(WR2PRE - 1);

    logic [CW-1:0] rcd_q, ras_q, rc_q, rp_q, rec_q;
    logic [CW-1:0] rec_dec, rec_col, rec_new;
    logic          auto_close;

    function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    // Limit flags: a limit is met when its counter has reached zero.
    always_comb begin
        rcd_ok = (rcd_q == '0);
        ras_ok = (ras_q == '0);
        rc_ok  = (rc_q  == '0);
        rp_ok  = (rp_q  == '0);
        rec_ok = (rec_q == '0);
    end

    // Column recovery: a new column command never shortens a longer wait.
    always_comb begin
        rec_dec = dec(rec_q);
        rec_col = wr_go ? L_WRP : L_RDP;
        rec_new = (rec_dec > rec_col) ? rec_dec : rec_col;
    end

    // The internal close fires in the first cycle both close limits are met.
    assign auto_close = (state == BK_CLOSING) && ras_ok && rec_ok;

    // Counter updates on accepted commands, otherwise a saturating count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_q <= '0;
            ras_q <= '0;
            rc_q  <= '0;
            rp_q  <= '0;
            rec_q <= '0;
        end else begin
            rcd_q <= act_go ? L_RCD : dec(rcd_q);
            ras_q <= act_go ? L_RAS : dec(ras_q);
            rc_q  <= act_go ? L_RC  : dec(rc_q);
            rp_q  <= (pre_go || auto_close) ? L_RP : dec(rp_q);
            if (act_go)
                rec_q <= '0;
            else if (rd_go || wr_go)
                rec_q <= rec_new;
            else
                rec_q <= rec_dec;
        end
    end

    // Row state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BK_IDLE;
        end else if (act_go) begin
            state <= BK_OPEN;
        end else if ((rd_go || wr_go) && ap) begin
            state <= BK_CLOSING;
        end else if (pre_go || auto_close) begin
            state <= BK_IDLE;
        end
    end

endmodule

// File: rtl/lbg_shared.sv
`timescale 1ns/1ps
// Limits that span all banks: row-open spacing, write-to-read turnaround
// and the refresh blackout. Counters load N-1 and reach zero N cycles on.
// Assumes go inputs are already qualified by the guard's legality.
module lbg_shared #(
    parameter int T_RRD = 2,
    parameter int WR2RD = 5,
    parameter int T_RFC = 8,
    parameter int CW    = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_go,
    input  logic wr_go,
    input  logic ref_go,
    output logic rrd_ok,
    output logic wtr_ok,
    output logic rfc_ok
);

    localparam logic [CW-1:0] L_RRD = CW'(T_RRD - 1);
    localparam logic [CW-1:0] L_WTR = CW'(WR2RD - 1);
    localparam logic [CW-1:0] L_RFC = CW'(T_RFC - 1);

    logic [CW-1:0] rrd_q, wtr_q, rfc_q;

    function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    // Limit flags for the shared counters.
    always_comb begin
        rrd_ok = (rrd_q == '0);
        wtr_ok = (wtr_q == '0);
        rfc_ok = (rfc_q == '0);
    end

    // Load on accepted commands, otherwise a saturating count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_q <= '0;
            wtr_q <= '0;
            rfc_q <= '0;
        end else begin
            rrd_q <= act_go ? L_RRD : dec(rrd_q);
            wtr_q <= wr_go  ? L_WTR : dec(wtr_q);
            rfc_q <= ref_go ? L_RFC : dec(rfc_q);
        end
    end

endmodule

// File: rtl/lpddr_bank_guard.sv
`timescale 1ns/1ps
// Command timing guard for a multi-bank low-power DDR memory.
// Each cycle it judges the presented command against the per-bank and
// shared limits, and books it when issue is strobed with cmd_ok high.
// Assumes the controller honours cmd_ok; a strobe without it is ignored.
module lpddr_bank_guard
    import lbg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RRD     = 2,
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 7,
    parameter int T_RC      = 11,
    parameter int T_RP      = 3,
    parameter int T_WR      = 3,
    parameter int T_WTR     = 2,
    parameter int T_RFC     = 8,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cmd_op,
    input  logic [BA_W-1:0]      cmd_bank,
    input  logic                 cmd_a10,
    input  logic                 cmd_issue,
    output logic                 cmd_ok,
    output logic                 cmd_illegal,
    output logic [NUM_BANKS-1:0] bank_open
);

    localparam int BEATS  = BURST_LEN / 2;
    localparam int RD2PRE = BEATS;
    localparam int WR2PRE = BEATS + 1 + T_WR;
    localparam int WR2RD  = BEATS + 1 + T_WTR;
    localparam int CW     = $clog2(T_RC + T_RAS + T_RFC + T_RRD + T_RP
                                   + T_RCD + WR2PRE + WR2RD + 2);

    op_e                  op;
    logic                 take;
    bank_st_e             st [NUM_BANKS];
    logic [NUM_BANKS-1:0] rcd_ok, ras_ok, rc_ok, rp_ok, rec_ok;
    logic [NUM_BANKS-1:0] is_idle, is_open, close_ready, close_hit;
    logic [NUM_BANKS-1:0] act_go, rd_go, wr_go, pre_go;
    logic                 rrd_ok, wtr_ok, rfc_ok;
    logic                 ok_raw, ill_raw;

    assign op   = op_e'(cmd_op);
    assign take = cmd_issue && cmd_ok;

    // Per-bank trackers and their qualified command strobes.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Decode this bank's share of the accepted command.
        always_comb begin
            act_go[b] = take && (op == OP_ACT) && (cmd_bank == BA_W'(b));
            rd_go[b]  = take && (op == OP_RD)  && (cmd_bank == BA_W'(b));
            wr_go[b]  = take && (op == OP_WR)  && (cmd_bank == BA_W'(b));
            pre_go[b] = take && (op == OP_PRE) && close_hit[b]
                        && (st[b] == BK_OPEN);
        end

        // State summaries used by the legality decision.
        always_comb begin
            is_idle[b]     = (st[b] == BK_IDLE);
            is_open[b]     = (st[b] == BK_OPEN);
            close_hit[b]   = cmd_a10 || (cmd_bank == BA_W'(b));
            close_ready[b] = is_idle[b]
                             || (is_open[b] && ras_ok[b] && rec_ok[b]);
        end

        lbg_bank #(
            .T_RCD  (T_RCD),
            .T_RAS  (T_RAS),
            .T_RC   (T_RC),
            .T_RP   (T_RP),
            .RD2PRE (RD2PRE),
            .WR2PRE (WR2PRE),
            .CW     (CW)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .act_go (act_go[b]),
            .rd_go  (rd_go[b]),
            .wr_go  (wr_go[b]),
            .ap     (cmd_a10),
            .pre_go (pre_go[b]),
            .state  (st[b]),
            .rcd_ok (rcd_ok[b]),
            .ras_ok (ras_ok[b]),
            .rc_ok  (rc_ok[b]),
            .rp_ok  (rp_ok[b]),
            .rec_ok (rec_ok[b])
        );

        assign bank_open[b] = !is_idle[b];
    end

    lbg_shared #(
        .T_RRD (T_RRD),
        .WR2RD (WR2RD),
        .T_RFC (T_RFC),
        .CW    (CW)
    ) u_shared (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_go (take && (op == OP_ACT)),
        .wr_go  (take && (op == OP_WR)),
        .ref_go (take && (op == OP_REF)),
        .rrd_ok (rrd_ok),
        .wtr_ok (wtr_ok),
        .rfc_ok (rfc_ok)
    );

    // Legality of the presented command against state and every limit.
    always_comb begin
        ok_raw  = 1'b0;
        ill_raw = 1'b0;
        unique case (op)
            OP_NOP: ok_raw = 1'b1;
            OP_ACT: begin
                ill_raw = is_open[cmd_bank];
                ok_raw  = is_idle[cmd_bank] && rp_ok[cmd_bank]
                          && rc_ok[cmd_bank] && rrd_ok;
            end
            OP_RD: begin
                ill_raw = !is_open[cmd_bank];
                ok_raw  = is_open[cmd_bank] && rcd_ok[cmd_bank] && wtr_ok;
            end
            OP_WR: begin
                ill_raw = !is_open[cmd_bank];
                ok_raw  = is_open[cmd_bank] && rcd_ok[cmd_bank];
            end
            OP_PRE: ok_raw = cmd_a10 ? (&close_ready) : close_ready[cmd_bank];
            OP_REF: begin
                ill_raw = |is_open;
                ok_raw  = (&is_idle) && (&rp_ok);
            end
            default: ill_raw = 1'b1;
        endcase
        if (!rfc_ok && (op != OP_NOP))
            ok_raw = 1'b0;
    end

    assign cmd_illegal = ill_raw;
    assign cmd_ok      = ok_raw && !ill_raw;

endmodule

// File: rtl/lpddr_bank_guard_chk.sv
`timescale 1ns/1ps
// Checker for the guard: it tracks elapsed cycles with its own counters
// and checks the limits the ports must honour. It is bound to the top.
module lpddr_bank_guard_chk
    import lbg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RRD     = 2,
    parameter int T_RCD     = 3,
    parameter int T_RFC     = 8,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           cmd_op,
    input logic [BA_W-1:0]      cmd_bank,
    input logic                 cmd_a10,
    input logic                 cmd_issue,
    input logic                 cmd_ok,
    input logic                 cmd_illegal,
    input logic [NUM_BANKS-1:0] bank_open
);

    logic [15:0] since_act, since_ref;
    logic [15:0] since_bank_act [NUM_BANKS];
    logic        took;

    assign took = cmd_issue && cmd_ok;

    // Cycles since the last accepted row open and refresh (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= 16'hFFFF;
            since_ref <= 16'hFFFF;
        end else begin
            if (took && cmd_op == OP_ACT) since_act <= 16'd1;
            else if (since_act != 16'hFFFF) since_act <= since_act + 16'd1;
            if (took && cmd_op == OP_REF) since_ref <= 16'd1;
            else if (since_ref != 16'hFFFF) since_ref <= since_ref + 16'd1;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cnt
        // Cycles since this bank's last accepted row open.
        always_ff @(posedge clk) begin
            if (!rst_n)
                since_bank_act[b] <= 16'hFFFF;
            else if (took && cmd_op == OP_ACT && cmd_bank == BA_W'(b))
                since_bank_act[b] <= 16'd1;
            else if (since_bank_act[b] != 16'hFFFF)
                since_bank_act[b] <= since_bank_act[b] + 16'd1;
        end
    end

    a_r1_reset_closed: assert property (@(posedge clk)
        $rose(rst_n) |-> bank_open == '0);

    a_r2_act_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_ACT && cmd_ok) |-> since_act >= 16'(T_RRD));

    a_r4_col_after_act: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_op == OP_RD || cmd_op == OP_WR) && cmd_ok)
        |-> since_bank_act[cmd_bank] >= 16'(T_RCD));

    a_r10_illegal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_illegal |-> !cmd_ok);

    a_r11_refresh_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_REF && cmd_ok) |-> bank_open == '0);

    a_r11_refresh_blackout: assert property (@(posedge clk) disable iff (!rst_n)
        (since_ref < 16'(T_RFC) && cmd_op != OP_NOP) |-> !cmd_ok);

    a_r12_open_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
        (|(bank_open & ~$past(bank_open)))
        |-> $past(cmd_issue && cmd_ok && cmd_op == OP_ACT));

endmodule

bind lpddr_bank_guard lpddr_bank_guard_chk #(
    .NUM_BANKS (NUM_BANKS),
    .T_RRD     (T_RRD),
    .T_RCD     (T_RCD),
    .T_RFC     (T_RFC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_op      (cmd_op),
    .cmd_bank    (cmd_bank),
    .cmd_a10     (cmd_a10),
    .cmd_issue   (cmd_issue),
    .cmd_ok      (cmd_ok),
    .cmd_illegal (cmd_illegal),
    .bank_open   (bank_open)
);

// File: tb/lpddr_bank_guard_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: drive tasks push the expected result of each cycle,
// and a monitor pops it and compares it with the design before the next edge.
// Defaults: T_RRD 2, T_RCD 3, T_RAS 7, T_RC 11, T_RP 3, T_WR 3, T_WTR 2,
// T_RFC 8, burst 4, so read-to-close is 2, write-to-close 6, write-to-read 5.
module lpddr_bank_guard_bench;

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                           PRE = 3'd4, REF = 3'd5, RSV = 3'd6;

    typedef struct {
        bit         chk_open;
        logic       ok;
        logic       ill;
        logic [3:0] open;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_op = NOP;
    logic [1:0] cmd_bank = '0;
    logic       cmd_a10 = 1'b0;
    logic       cmd_issue = 1'b0;
    logic       cmd_ok, cmd_illegal;
    logic [3:0] bank_open;

    item_t q[$];
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    lpddr_bank_guard u_lpddr_bank_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_op      (cmd_op),
        .cmd_bank    (cmd_bank),
        .cmd_a10     (cmd_a10),
        .cmd_issue   (cmd_issue),
        .cmd_ok      (cmd_ok),
        .cmd_illegal (cmd_illegal),
        .bank_open   (bank_open)
    );

    // Drive one cycle and queue its expected verdict.
    task automatic drive(input logic [2:0] op, input logic [1:0] bk,
                         input logic a10, input logic iss,
                         input logic eok, input logic eill, input string tag);
        item_t it;
        @(negedge clk);
        cmd_op = op; cmd_bank = bk; cmd_a10 = a10; cmd_issue = iss;
        it.chk_open = 1'b0; it.ok = eok; it.ill = eill; it.open = '0; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic probe(input logic [2:0] op, input logic [1:0] bk,
                         input logic a10, input logic eok, input logic eill,
                         input string tag);
        drive(op, bk, a10, 1'b0, eok, eill, tag);
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] bk,
                         input logic a10, input string tag);
        drive(op, bk, a10, 1'b1, 1'b1, 1'b0, tag);
    endtask

    task automatic expect_open(input logic [3:0] m, input string tag);
        item_t it;
        @(negedge clk);
        cmd_op = NOP; cmd_bank = '0; cmd_a10 = 1'b0; cmd_issue = 1'b0;
        it.chk_open = 1'b1; it.ok = 1'b1; it.ill = 1'b0; it.open = m; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_op = NOP; cmd_issue = 1'b0; cmd_a10 = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_op = NOP; cmd_issue = 1'b0; cmd_a10 = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compare queued expectations just before the next rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_run++;
                if (it.chk_open) begin
                    if (bank_open !== it.open) begin
                        n_fail++;
                        $display("FAIL %s bank_open actual=%b expected=%b",
                                 it.tag, bank_open, it.open);
                    end
                end else if (cmd_ok !== it.ok || cmd_illegal !== it.ill) begin
                    n_fail++;
                    $display("FAIL %s ok/illegal actual=%b/%b expected=%b/%b",
                             it.tag, cmd_ok, cmd_illegal, it.ok, it.ill);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL all-requirements watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        expect_open(4'b0000, "R1 reset mask");
        probe(ACT, 2'd0, 0, 1, 0, "R1 open bank0 after reset");
        probe(ACT, 2'd3, 0, 1, 0, "R1 open bank3 after reset");
        probe(REF, 2'd0, 0, 1, 0, "R1 refresh after reset");
        probe(RD,  2'd0, 0, 0, 1, "R10 read of idle bank");
        probe(WR,  2'd2, 0, 0, 1, "R10 write of idle bank");

        // Spacing, activation delay, explicit close, turnaround
        do_reset();
        issue(ACT, 2'd0, 0, "R2 open bank0");                    // c
        probe(RD,  2'd0, 0, 0, 0, "R4 read before T_RCD");        // c+1
        issue(ACT, 2'd1, 0, "R2 open bank1 at T_RRD");            // c+2
        probe(RD,  2'd0, 0, 1, 0, "R4 read at T_RCD");            // c+3
        expect_open(4'b0011, "R2 two rows open");                 // c+4
        probe(ACT, 2'd0, 0, 0, 1, "R10 open of open bank");       // c+5
        probe(PRE, 2'd0, 0, 0, 0, "R5 close before T_RAS");       // c+6
        issue(PRE, 2'd0, 0, "R5 close at T_RAS");                 // c+7
        expect_open(4'b0010, "R8 single close");                  // c+8
        probe(ACT, 2'd0, 0, 0, 0, "R6 reopen too soon");          // c+9
        idle(1);                                                  // c+10
        issue(WR,  2'd1, 0, "R4 write bank1");                    // c+11
        idle(3);                                                  // c+12..14
        probe(RD,  2'd1, 0, 0, 0, "R7 read before turnaround");   // c+15
        probe(PRE, 2'd1, 0, 0, 0, "R5 close before write recovery"); // c+16
        probe(RD,  2'd1, 0, 1, 0, "R7 read after turnaround");    // c+17
        issue(PRE, 2'd2, 1, "R8 close-all with idle banks");      // c+18
        expect_open(4'b0000, "R8 close-all result");              // c+19
        drive(ACT, 2'd1, 0, 1, 0, 0, "R12 early open strobed");   // c+20
        expect_open(4'b0000, "R12 refused open left no row");     // c+21

        // Same-bank row cycle
        do_reset();
        issue(ACT, 2'd2, 0, "R3 open bank2");                     // c
        idle(6);
        issue(PRE, 2'd2, 0, "R3 close bank2");                    // c+7
        idle(2);
        probe(ACT, 2'd2, 0, 0, 0, "R3 reopen before T_RC");       // c+10
        probe(ACT, 2'd2, 0, 1, 0, "R3 reopen at T_RC");           // c+11

        // Write with auto-close: recovery outlasts row-active minimum
        do_reset();
        issue(ACT, 2'd0, 0, "R9 open bank0");                     // c
        idle(1);
        issue(ACT, 2'd1, 0, "R9 open bank1");                     // c+2
        issue(WR,  2'd0, 1, "R9 write with auto-close");          // c+3
        probe(RD,  2'd0, 0, 0, 1, "R9 read of closing bank");     // c+4
        issue(WR,  2'd1, 0, "R9 other bank usable");              // c+5
        probe(PRE, 2'd0, 0, 0, 0, "R9 close of closing bank");    // c+6
        probe(PRE, 2'd0, 1, 0, 0, "R9 close-all while closing");  // c+7
        expect_open(4'b0011, "R9 still closing");                 // c+8
        expect_open(4'b0011, "R9 closes this cycle");             // c+9
        expect_open(4'b0010, "R9 closed after write recovery");   // c+10
        probe(ACT, 2'd0, 0, 0, 0, "R6 reopen before T_RP");       // c+11
        probe(ACT, 2'd0, 0, 1, 0, "R6 reopen at T_RP");           // c+12

        // Read with auto-close: row-active minimum dominates
        do_reset();
        issue(ACT, 2'd3, 0, "R9 open bank3");                     // c
        idle(2);
        issue(RD,  2'd3, 1, "R9 read with auto-close");           // c+3
        idle(3);
        expect_open(4'b1000, "R9 held until T_RAS");              // c+7
        expect_open(4'b0000, "R9 closed after T_RAS");            // c+8

        // Refresh
        do_reset();
        issue(ACT, 2'd1, 0, "R11 open bank1");                    // c
        probe(REF, 2'd0, 0, 0, 1, "R10 refresh with open bank");  // c+1
        idle(5);
        issue(PRE, 2'd1, 0, "R11 close bank1");                   // c+7
        probe(REF, 2'd0, 0, 0, 0, "R11 refresh during T_RP");     // c+8
        probe(REF, 2'd0, 0, 0, 0, "R11 refresh during T_RP");     // c+9
        issue(REF, 2'd0, 0, "R11 refresh accepted");              // c+10
        probe(ACT, 2'd2, 0, 0, 0, "R11 open in blackout");        // c+11
        probe(NOP, 2'd0, 0, 1, 0, "R11 no-op in blackout");       // c+12
        probe(RSV, 2'd0, 0, 0, 1, "R10 reserved code");           // c+13
        idle(3);
        probe(ACT, 2'd2, 0, 0, 0, "R11 open at end of blackout"); // c+17
        probe(ACT, 2'd2, 0, 1, 0, "R11 open after blackout");     // c+18

        @(negedge clk);
        cmd_op = NOP; cmd_issue = 1'b0;
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule